// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is a serial configuration port that writes one of three internal registers from a serial clock and data stream. An active-low enable frames each transfer. The stream carries no address or steering bits. The destination is chosen only by how many serial clock rising edges arrive while the enable is low. Certain lengths form a reset command. Very long frames are pass-through traffic for a downstream device on the serial output.

The serial clock, serial data and enable are asynchronous to the system clock. They are brought in through a synchronizer, and their edges are detected in the system clock domain. Bits shift in most significant first. The length is counted, and the count saturates. The three registers hold their values for the whole frame. The load or the reset is applied only when the enable rises. The serial output advances on serial clock falling edges and presents a bit received a fixed number of rising edges earlier.

Top module: `sreg_loader`

## Requirements
- R1: With enable low, each serial clock rising edge shifts in one data bit, most significant first. A frame of exactly 8 edges loads the 8-bit control register with the last 8 bits, so the first bit of the frame lands in bit 7.
- R2: A frame of exactly 16 edges loads the 16-bit divide register with the 16 bits received, so the first bit lands in bit 15.
- R3: A frame of exactly 15 edges loads the 15-bit reference register with the 15 bits received, so the first bit lands in bit 14.
- R4: A frame of exactly 24 edges loads the reference register with the last 15 bits received. The first 9 bits are discarded.
- R5: A frame of 9 to 13 edges returns all three registers to their parameter initial values. It also raises `reset_pulse` for exactly one system clock cycle.
- R6: A frame of any other length from 0 to 32 edges leaves all three registers unchanged and produces no reset pulse.
- R7: The edge count saturates at 33. A frame longer than 32 edges changes no register and does not wrap into a valid length, including 41 and 48 edges.
- R8: The three registers keep their previous values while a frame is shifting. They can change only in the cycle after the enable rise is detected.
- R9: `sdout` changes only after a detected serial clock falling edge while enable is low. After the falling edge that follows the k-th rising edge, `sdout` equals the bit captured PASS_DEPTH-1 rising edges before edge k. This counts across frames, and the history is zero after reset.
- R10: After reset the registers hold C_INIT, N_INIT and R_INIT, and `sdout` and `reset_pulse` are 0.
- R11: Serial clock edges while enable is high neither shift, count nor move `sdout`. The edge count restarts from zero when enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| en_n_i | input | 1 | Active-low frame enable, asynchronous |
| c_reg | output | 8 | Control register |
| n_reg | output | 16 | Divide register |
| r_reg | output | 15 | Reference register |
| sdout | output | 1 | Serial pass-through output |
| reset_pulse | output | 1 | One-cycle pulse on a reset command |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default 2, so the checks must hold with a deeper synchronizer. It sets nonzero initial values (8'h3C, 16'h1234, 15'h0ABC), so a reset command is visible on all three registers. PASS_DEPTH is left at 16. With these values, cascade frames of 33 to 48 edges push bits all the way through to `sdout`, and the bench can compare each of them against its own bit history.

// File: rtl/sload_pkg.sv
package sload_pkg;

    localparam int C_W = 8;
    localparam int N_W = 16;
    localparam int R_W = 15;

    localparam int LEN_C       = 8;
    localparam int LEN_N       = 16;
    localparam int LEN_R_SHORT = 15;
    localparam int LEN_R_LONG  = 24;
    localparam int LEN_RST_MIN = 9;
    localparam int LEN_RST_MAX = 13;
    localparam int LEN_PLAIN   = 32;

    localparam int CNT_SAT = LEN_PLAIN + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);
    localparam int SHIFT_W = LEN_R_LONG;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_LOAD_C,
        ACT_LOAD_N,
        ACT_LOAD_R,
        ACT_RESET,
        ACT_CASCADE
    } action_e;

    // Synchronized pin events in the system clock domain
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic en_fall;
        logic en_rise;
        logic en_low;
        logic sdata;
    } pin_ev_t;

    function automatic action_e classify(input cnt_t n);
        int v;
        v = int'(n);
        if (v == LEN_C)                               return ACT_LOAD_C;
        if (v == LEN_N)                               return ACT_LOAD_N;
        if (v == LEN_R_SHORT || v == LEN_R_LONG)      return ACT_LOAD_R;
        if (v >= LEN_RST_MIN && v <= LEN_RST_MAX)     return ACT_RESET;
        if (v > LEN_PLAIN)                            return ACT_CASCADE;
        return ACT_NONE;
    endfunction

    function automatic cnt_t sat_inc(input cnt_t n);
        if (int'(n) >= CNT_SAT) return n;
        return n + cnt_t'(1);
    endfunction

endpackage

// File: rtl/sload_sync.sv
module sload_sync
    import sload_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_i,
    input  logic    sdata_i,
    input  logic    en_n_i,
    output pin_ev_t ev
);
    localparam int B_DATA = 0;
    localparam int B_SCLK = 1;
    localparam int B_EN   = 2;
    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [2:0] stage_q [SYNC_STAGES];
    logic       sclk_prev_q;
    logic       en_prev_q;
    logic [2:0] s_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= IDLE_PINS;
            sclk_prev_q <= 1'b0;
            en_prev_q   <= 1'b1;
        end else begin
            stage_q[0] <= {en_n_i, sclk_i, sdata_i};
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            sclk_prev_q <= stage_q[SYNC_STAGES-1][B_SCLK];
            en_prev_q   <= stage_q[SYNC_STAGES-1][B_EN];
        end
    end

    assign s_last = stage_q[SYNC_STAGES-1];

    always_comb begin
        ev.sclk_rise = s_last[B_SCLK] & ~sclk_prev_q;
        ev.sclk_fall = ~s_last[B_SCLK] & sclk_prev_q;
        ev.en_fall   = ~s_last[B_EN] & en_prev_q;
        ev.en_rise   = s_last[B_EN] & ~en_prev_q;
        ev.en_low    = ~s_last[B_EN];
        ev.sdata     = s_last[B_DATA];
    end

endmodule

// File: rtl/sload_shift.sv
module sload_shift
    import sload_pkg::*;
#(
    parameter int PASS_DEPTH = 16   // 1 .. SHIFT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  pin_ev_t            ev,
    output logic [SHIFT_W-1:0] shift_q,
    output cnt_t               cnt_q,
    output logic               sdout_q
);
    logic shift_en;
    logic out_en;

    assign shift_en = ev.en_low & ev.sclk_rise;
    assign out_en   = ev.en_low & ev.sclk_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
            sdout_q <= 1'b0;
        end else begin
            if (ev.en_fall) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                shift_q <= {shift_q[SHIFT_W-2:0], ev.sdata};
                cnt_q   <= sat_inc(cnt_q);
            end
            if (out_en) sdout_q <= shift_q[PASS_DEPTH-1];
        end
    end

endmodule

// File: rtl/sload_regs.sv
module sload_regs
    import sload_pkg::*;
#(
    parameter logic [C_W-1:0] C_INIT = '0,
    parameter logic [N_W-1:0] N_INIT = '0,
    parameter logic [R_W-1:0] R_INIT = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_end,
    input  cnt_t               cnt,
    input  logic [SHIFT_W-1:0] shift,
    output logic [C_W-1:0]     c_q,
    output logic [N_W-1:0]     n_q,
    output logic [R_W-1:0]     r_q,
    output logic               pulse_q
);
    action_e act;

    always_comb act = frame_end ? classify(cnt) : ACT_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q     <= C_INIT;
            n_q     <= N_INIT;
            r_q     <= R_INIT;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            case (act)
                ACT_LOAD_C: c_q <= shift[C_W-1:0];
                ACT_LOAD_N: n_q <= shift[N_W-1:0];
                ACT_LOAD_R: r_q <= shift[R_W-1:0];
                ACT_RESET: begin
                    c_q     <= C_INIT;
                    n_q     <= N_INIT;
                    r_q     <= R_INIT;
                    pulse_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
    import sload_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              PASS_DEPTH  = 16,
    parameter logic [C_W-1:0]  C_INIT      = '0,
    parameter logic [N_W-1:0]  N_INIT      = '0,
    parameter logic [R_W-1:0]  R_INIT      = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk_i,
    input  logic           sdata_i,
    input  logic           en_n_i,
    output logic [C_W-1:0] c_reg,
    output logic [N_W-1:0] n_reg,
    output logic [R_W-1:0] r_reg,
    output logic           sdout,
    output logic           reset_pulse
);
    pin_ev_t            ev;
    logic [SHIFT_W-1:0] shift_q;
    cnt_t               cnt_q;

    sload_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(sclk_i), .sdata_i(sdata_i), .en_n_i(en_n_i),
        .ev(ev)
    );

    sload_shift #(.PASS_DEPTH(PASS_DEPTH)) u_shift (
        .clk(clk), .rst(rst), .ev(ev),
        .shift_q(shift_q), .cnt_q(cnt_q), .sdout_q(sdout)
    );

    sload_regs #(.C_INIT(C_INIT), .N_INIT(N_INIT), .R_INIT(R_INIT)) u_regs (
        .clk(clk), .rst(rst),
        .frame_end(ev.en_rise), .cnt(cnt_q), .shift(shift_q),
        .c_q(c_reg), .n_q(n_reg), .r_q(r_reg), .pulse_q(reset_pulse)
    );

endmodule

// File: rtl/sload_checker.sv
module sload_checker
    import sload_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input pin_ev_t        ev,
    input cnt_t           cnt_q,
    input logic           sdout,
    input logic [C_W-1:0] c_reg,
    input logic [N_W-1:0] n_reg,
    input logic [R_W-1:0] r_reg,
    input logic           reset_pulse
);
    // R8: registers move only right after a frame end
    a_r8_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !ev.en_rise |=> ($stable(c_reg) && $stable(n_reg) && $stable(r_reg)));

    // R7: edge count never goes past the saturation value
    a_r7_cnt_sat: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= CNT_SAT);

    // R9: serial output moves only after a falling serial clock edge
    a_r9_sdout_edge: assert property (@(posedge clk) disable iff (rst)
        !ev.sclk_fall |=> $stable(sdout));

    // R11: count restarts when enable falls
    a_r11_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        ev.en_fall |=> (cnt_q == '0));

    // R11: rising edges with enable high do not count
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (ev.sclk_rise && !ev.en_low && !ev.en_fall) |=> $stable(cnt_q));

    // R5: reset pulse lasts a single cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |=> !reset_pulse);

endmodule

bind sreg_loader sload_checker u_chk (
    .clk(clk), .rst(rst), .ev(ev), .cnt_q(cnt_q), .sdout(sdout),
    .c_reg(c_reg), .n_reg(n_reg), .r_reg(r_reg), .reset_pulse(reset_pulse)
);

// File: tb/tb_sreg_loader.sv
module tb_sreg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int DEPTH      = 16;
    localparam logic [7:0]  TB_C0 = 8'h3C;
    localparam logic [15:0] TB_N0 = 16'h1234;
    localparam logic [14:0] TB_R0 = 15'h0ABC;

    logic clk = 1'b0, rst = 1'b1;
    logic sclk_i = 1'b0, sdata_i = 1'b0, en_n_i = 1'b1;
    logic [7:0]  c_reg;
    logic [15:0] n_reg;
    logic [14:0] r_reg;
    logic        sdout, reset_pulse;

    int checks = 0, fails = 0, pulse_cycles = 0, exp_pulses = 0;
    bit done = 1'b0;
    logic [7:0]  e_c = TB_C0;
    logic [15:0] e_n = TB_N0;
    logic [14:0] e_r = TB_R0;
    logic [23:0] hist = '0;
    logic        e_sd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_loader #(.SYNC_STAGES(3), .PASS_DEPTH(DEPTH),
                  .C_INIT(TB_C0), .N_INIT(TB_N0), .R_INIT(TB_R0)) dut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i), .en_n_i(en_n_i),
        .c_reg(c_reg), .n_reg(n_reg), .r_reg(r_reg), .sdout(sdout),
        .reset_pulse(reset_pulse));

    always @(posedge clk) if (!rst && reset_pulse) pulse_cycles++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string req_of(input int n);
        if (n == 8) return "R1";
        if (n == 16) return "R2";
        if (n == 15) return "R3";
        if (n == 24) return "R4";
        if (n >= 9 && n <= 13) return "R5";
        if (n > 32) return "R7";
        return "R6";
    endfunction

    task automatic check_regs(input string req);
        chk(c_reg == e_c, req, "c_reg", 32'(c_reg), 32'(e_c));
        chk(n_reg == e_n, req, "n_reg", 32'(n_reg), 32'(e_n));
        chk(r_reg == e_r, req, "r_reg", 32'(r_reg), 32'(e_r));
        chk(pulse_cycles == exp_pulses, req, "reset pulse cycles",
            32'(pulse_cycles), 32'(exp_pulses));
    endtask

    task automatic send_frame(input logic [47:0] bits, input int n);
        en_n_i = 1'b0;
        wait_n(HALF);
        for (int k = 0; k < n; k++) begin
            sdata_i = bits[n-1-k];
            wait_n(HALF);
            chk(sdout == e_sd, "R9", "sdout before rise", 32'(sdout), 32'(e_sd));
            sclk_i = 1'b1;
            hist   = {hist[22:0], bits[n-1-k]};
            wait_n(HALF);
            chk(sdout == e_sd, "R9", "sdout held over rise", 32'(sdout), 32'(e_sd));
            sclk_i = 1'b0;
            e_sd   = hist[DEPTH-1];
            wait_n(HALF);
            chk(sdout == e_sd, "R9", "sdout after fall", 32'(sdout), 32'(e_sd));
            if (k == n/2) check_regs("R8");
        end
        en_n_i = 1'b1;
        if (n == 8) e_c = hist[7:0];
        else if (n == 16) e_n = hist[15:0];
        else if (n == 15 || n == 24) e_r = hist[14:0];
        else if (n >= 9 && n <= 13) begin
            e_c = TB_C0; e_n = TB_N0; e_r = TB_R0; exp_pulses++;
        end
        wait_n(2*HALF + 4);
        check_regs(req_of(n));
    endtask

    // sclk activity with enable high (R11)
    task automatic idle_toggles(input int n);
        for (int k = 0; k < n; k++) begin
            sdata_i = 1'($urandom);
            sclk_i = 1'b1; wait_n(HALF);
            sclk_i = 1'b0; wait_n(HALF);
        end
        wait_n(HALF);
        chk(sdout == e_sd, "R11", "sdout after idle toggles", 32'(sdout), 32'(e_sd));
        check_regs("R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lens [14] = '{8, 16, 15, 24, 9, 13, 11, 7, 14, 32, 33, 41, 48, 1};
        int pool [12] = '{8, 16, 15, 24, 10, 12, 3, 20, 25, 31, 36, 0};
        void'($urandom(32'h5EED));
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        chk(c_reg == TB_C0, "R10", "c_reg reset", 32'(c_reg), 32'(TB_C0));
        chk(n_reg == TB_N0, "R10", "n_reg reset", 32'(n_reg), 32'(TB_N0));
        chk(r_reg == TB_R0, "R10", "r_reg reset", 32'(r_reg), 32'(TB_R0));
        chk(sdout == 1'b0, "R10", "sdout reset", 32'(sdout), 32'd0);
        chk(reset_pulse == 1'b0, "R10", "reset_pulse reset", 32'(reset_pulse), 32'd0);

        // directed: fixed patterns, then the length list
        send_frame(48'h0000_0000_00A7, 8);       // R1
        send_frame(48'h0000_0000_C35A, 16);      // R2
        send_frame(48'h0000_0000_5A5A, 15);      // R3
        send_frame(48'h0000_00FF_8001, 24);      // R4
        idle_toggles(5);                         // R11
        send_frame(48'h0000_0000_0001, 8);       // R11: count restarted cleanly
        for (int i = 0; i < 14; i++) begin
            send_frame({16'($urandom), 32'($urandom)}, lens[i]);
            if (i == 6) idle_toggles(3);
        end
        // random frames from the length pool
        for (int i = 0; i < 60; i++) begin
            send_frame({16'($urandom), 32'($urandom)}, pool[$urandom % 12]);
            if ($urandom % 8 == 0) idle_toggles(1 + int'($urandom % 4));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule